// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the word-address sequence for one DMA channel that moves 32-bit words between memory and a peripheral. Software programs a base word address, a line length, a line stride, a line count, a direction bit and the enables. A start pulse then launches the channel. The block offers one address at a time on a valid/ready output. The data mover accepts an address by raising ready. One accepted address stands for one word moved.

There are two modes. In rectangular mode the channel walks a set of lines, each a fixed number of words long. Successive lines begin one stride apart. When the last word of the last line is accepted, the channel raises a sticky done flag and goes idle. A line length of zero selects circular mode instead. The address then climbs through a ring of stride × (count + 1) words and wraps back to the base without end. A flag is raised at the end of each half of the ring.

The flags are cleared by write-one pulses. A single interrupt line reports them, gated by an interrupt enable. A stop input drops the channel to idle at once.

Back-pressure rules: while `addr_valid` is high and `addr_ready` is low, `addr` and `addr_dir` hold their values. `addr_valid` falls only after the final accepted address of a rectangular walk, or on a stop. A new start restarts the walk.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is 0, all three flags are 0 and `irq` is 0.
- R2: A `start` pulse without `stop` latches the configuration. When `cfg_line_len` is nonzero, the channel enters rectangular mode and the first address offered, on the next cycle, is `cfg_base`.
- R3: In rectangular mode the k-th accepted address is base + (k / len)·stride + (k mod len), modulo the address width. `cfg_line_cnt` holds the number of lines minus one, so a value of N gives N+1 lines of `cfg_line_len` words.
- R4: The address advances only on a cycle where `addr_valid` and `addr_ready` are both high. Otherwise `addr` and `addr_dir` hold.
- R5: The cycle after the last word of the last line is accepted, `addr_valid` is 0 and flag bit 0 (done) is 1. The flag stays set until it is cleared.
- R6: A start with `cfg_line_len` = 0 runs circular mode only if both `cfg_loop_en` and `cfg_half_b_en` are 1. Otherwise the channel stays idle and no address is offered.
- R7: In circular mode the address runs from base upward through stride·(count+1) words and then returns to base, with no end.
- R8: In circular mode, flag bit 1 (half A) is set when the word at ring index size/2−1 is accepted. Flag bit 2 (half B) is set when the word at index size−1 is accepted. This happens on every pass.
- R9: `addr_dir` equals the `cfg_dir` value latched at start: 1 means memory to device, 0 means device to memory.
- R10: Flags latch whatever the interrupt enable is. `irq` is 1 exactly when `cfg_irq_en` is 1 and at least one flag is set.
- R11: A 1 on `irq_clr` bit i clears flag bit i on the next edge. The bits are 0 = done, 1 = half A, 2 = half B. A set in the same cycle wins over the clear.
- R12: `stop` makes `addr_valid` 0 on the next cycle. A transfer accepted in the stop cycle raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse (write of the base address) |
| stop | input | 1 | Abort to idle, wins over start |
| cfg_base | input | 30 | Base word address (byte address >> 2) |
| cfg_line_len | input | 12 | Words per line; 0 selects circular mode |
| cfg_stride | input | 16 | Words from one line start to the next |
| cfg_line_cnt | input | 12 | Number of lines minus one |
| cfg_dir | input | 1 | 1 memory to device, 0 device to memory |
| cfg_loop_en | input | 1 | Circular mode enable |
| cfg_half_b_en | input | 1 | Second-half interrupt enable, needed for circular mode |
| cfg_irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 3 | Write-one clear per flag |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Word moved for the offered address |
| addr | output | 30 | Current word address |
| addr_dir | output | 1 | Latched direction |
| flags | output | 3 | Sticky flags: done, half A, half B |
| irq | output | 1 | Masked interrupt |

## Verification
Some rules are checked on every cycle. The address and direction must hold while back-pressure lasts. A stop must empty the channel a cycle later. A start in circular mode without both enables must leave the channel idle. The done flag must stay set until it is cleared, and a flag may only rise after an accepted transfer. The interrupt must stay low while it is disabled. Other behaviour can only be shown by the bench's scenarios, which compare against a model: the exact address order of both modes, the wrap point of the ring, the index at which each half flag fires, and the cycle at which a walk completes. The scenarios mix random stalls and clears with single-word, wrap-around and stop-in-flight cases.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RECT = 2'd1,
    CH_RING = 2'd2
  } ch_mode_e;

  localparam int FLAG_DONE  = 0;
  localparam int FLAG_HALFA = 1;
  localparam int FLAG_HALFB = 2;
  localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/dma2d_rect_seq.sv
module dma2d_rect_seq #(
  parameter int AW = 30,
  parameter int LW = 12,
  parameter int SW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] line_len,
  input  logic [SW-1:0] stride,
  input  logic [CW-1:0] line_cnt,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          last_word
);
  logic [LW-1:0] len_q, word_q;
  logic [SW-1:0] stride_q;
  logic [CW-1:0] cnt_q, line_q;
  logic [AW-1:0] line_start_q, addr_q;
  logic          line_end;
  logic [AW-1:0] next_line_start;

  assign line_end        = (word_q == len_q - LW'(1));
  assign last_word       = line_end && (line_q == cnt_q);
  assign next_line_start = line_start_q + AW'(stride_q);
  assign addr            = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q        <= '0;
      word_q       <= '0;
      stride_q     <= '0;
      cnt_q        <= '0;
      line_q       <= '0;
      line_start_q <= '0;
      addr_q       <= '0;
    end else if (load) begin
      len_q        <= line_len;
      stride_q     <= stride;
      cnt_q        <= line_cnt;
      word_q       <= '0;
      line_q       <= '0;
      line_start_q <= base;
      addr_q       <= base;
    end else if (adv) begin
      if (line_end) begin
        word_q       <= '0;
        line_q       <= line_q + CW'(1);
        line_start_q <= next_line_start;
        addr_q       <= next_line_start;
      end else begin
        word_q <= word_q + LW'(1);
        addr_q <= addr_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/dma2d_ring_seq.sv
module dma2d_ring_seq #(
  parameter int AW = 30,
  parameter int SW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] stride,
  input  logic [CW-1:0] line_cnt,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          at_half_end,
  output logic          at_ring_end
);
  localparam int ZW = SW + CW + 1;

  logic [ZW-1:0] size_q, half_q, idx_q, size_d;
  logic [AW-1:0] base_q, addr_q;

  assign size_d      = ZW'(stride) * (ZW'(line_cnt) + ZW'(1));
  assign at_half_end = (idx_q == half_q - ZW'(1));
  assign at_ring_end = (idx_q == size_q - ZW'(1));
  assign addr        = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      half_q <= '0;
      idx_q  <= '0;
      base_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      size_q <= size_d;
      half_q <= size_d >> 1;
      idx_q  <= '0;
      base_q <= base;
      addr_q <= base;
    end else if (adv) begin
      if (at_ring_end) begin
        idx_q  <= '0;
        addr_q <= base_q;
      end else begin
        idx_q  <= idx_q + ZW'(1);
        addr_q <= addr_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/dma2d_flag_bank.sv
module dma2d_flag_bank #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic          irq_en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] flags_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags_q[i] <= 1'b0;
      else if (set[i]) flags_q[i] <= 1'b1;
      else if (clr[i]) flags_q[i] <= 1'b0;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_en && (|flags_q);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 30,
  parameter int LW = 12,
  parameter int SW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_line_len,
  input  logic [SW-1:0] cfg_stride,
  input  logic [CW-1:0] cfg_line_cnt,
  input  logic          cfg_dir,
  input  logic          cfg_loop_en,
  input  logic          cfg_half_b_en,
  input  logic          cfg_irq_en,
  input  logic [2:0]    irq_clr,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic          addr_dir,
  output logic [2:0]    flags,
  output logic          irq
);
  import dma2d_pkg::*;

  ch_mode_e mode_q, start_mode;
  logic     dir_q;
  logic     load, fire, quiet;
  logic     rect_last, ring_half, ring_end;
  logic [AW-1:0] rect_addr, ring_addr;
  logic [NUM_FLAGS-1:0] flag_set;

  assign load  = start && !stop;
  assign quiet = !start && !stop;
  assign fire  = addr_valid && addr_ready;

  always_comb begin
    if (cfg_line_len != '0)                start_mode = CH_RECT;
    else if (cfg_loop_en && cfg_half_b_en) start_mode = CH_RING;
    else                                   start_mode = CH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= CH_IDLE;
      dir_q  <= 1'b0;
    end else if (stop) begin
      mode_q <= CH_IDLE;
    end else if (start) begin
      mode_q <= start_mode;
      dir_q  <= cfg_dir;
    end else if (fire && mode_q == CH_RECT && rect_last) begin
      mode_q <= CH_IDLE;
    end
  end

  dma2d_rect_seq #(.AW(AW), .LW(LW), .SW(SW), .CW(CW)) u_rect (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .base      (cfg_base),
    .line_len  (cfg_line_len),
    .stride    (cfg_stride),
    .line_cnt  (cfg_line_cnt),
    .adv       (fire && quiet && mode_q == CH_RECT),
    .addr      (rect_addr),
    .last_word (rect_last)
  );

  dma2d_ring_seq #(.AW(AW), .SW(SW), .CW(CW)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .base        (cfg_base),
    .stride      (cfg_stride),
    .line_cnt    (cfg_line_cnt),
    .adv         (fire && quiet && mode_q == CH_RING),
    .addr        (ring_addr),
    .at_half_end (ring_half),
    .at_ring_end (ring_end)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_DONE]  = fire && quiet && mode_q == CH_RECT && rect_last;
    flag_set[FLAG_HALFA] = fire && quiet && mode_q == CH_RING && ring_half;
    flag_set[FLAG_HALFB] = fire && quiet && mode_q == CH_RING && ring_end;
  end

  dma2d_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flag_set),
    .clr    (irq_clr),
    .irq_en (cfg_irq_en),
    .flags  (flags),
    .irq    (irq)
  );

  assign addr_valid = (mode_q != CH_IDLE);
  assign addr       = (mode_q == CH_RING) ? ring_addr : rect_addr;
  assign addr_dir   = dir_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 30,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic [LW-1:0] cfg_line_len,
  input logic          cfg_loop_en,
  input logic          cfg_half_b_en,
  input logic          cfg_irq_en,
  input logic [2:0]    irq_clr,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          addr_dir,
  input logic [2:0]    flags,
  input logic          irq
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && !start && !stop
      |=> addr_valid && $stable(addr) && $stable(addr_dir));

  assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !addr_valid);

  assert_ring_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !stop && cfg_line_len == '0 && !(cfg_loop_en && cfg_half_b_en)
      |=> !addr_valid);

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !irq_clr[0] |=> flags[0]);

  assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(addr_valid && addr_ready));

  assert_half_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[1]) || $rose(flags[2])) |-> $past(addr_valid && addr_ready));

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .stop          (stop),
  .cfg_line_len  (cfg_line_len),
  .cfg_loop_en   (cfg_loop_en),
  .cfg_half_b_en (cfg_half_b_en),
  .cfg_irq_en    (cfg_irq_en),
  .irq_clr       (irq_clr),
  .addr_valid    (addr_valid),
  .addr_ready    (addr_ready),
  .addr          (addr),
  .addr_dir      (addr_dir),
  .flags         (flags),
  .irq           (irq)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0;
  logic [29:0] cfg_base = '0;
  logic [11:0] cfg_line_len = '0;
  logic [15:0] cfg_stride = '0;
  logic [11:0] cfg_line_cnt = '0;
  logic        cfg_dir = 1'b0, cfg_loop_en = 1'b0, cfg_half_b_en = 1'b0, cfg_irq_en = 1'b0;
  logic [2:0]  irq_clr = '0;
  logic        addr_valid, addr_ready = 1'b0, addr_dir, irq;
  logic [29:0] addr;
  logic [2:0]  flags;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_stride(cfg_stride),
    .cfg_line_cnt(cfg_line_cnt), .cfg_dir(cfg_dir), .cfg_loop_en(cfg_loop_en),
    .cfg_half_b_en(cfg_half_b_en), .cfg_irq_en(cfg_irq_en), .irq_clr(irq_clr),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .addr_dir(addr_dir), .flags(flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] rect_exp(input logic [29:0] base, input int len,
                                           input int stride, input int k);
    logic [29:0] r;
    r = base + 30'(k / len) * 30'(stride) + 30'(k % len);
    return r;
  endfunction

  task automatic launch(input logic [29:0] b, input int len, input int stride,
                        input int cnt, input bit dir, input bit lp, input bit hb,
                        input bit ie);
    @(negedge clk);
    cfg_base = b; cfg_line_len = 12'(len); cfg_stride = 16'(stride);
    cfg_line_cnt = 12'(cnt); cfg_dir = dir; cfg_loop_en = lp; cfg_half_b_en = hb;
    cfg_irq_en = ie; start = 1'b1; irq_clr = 3'b111; addr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; irq_clr = 3'b000;
  endtask

  // Runs a rectangular walk with random stalls; ends at the negedge after completion.
  task automatic run_rect(input logic [29:0] b, input int len, input int stride,
                          input int cnt, input bit dir, input bit ie, input int stall);
    int total, k;
    bit prev_fire;
    logic [29:0] prev_addr;
    total = len * (cnt + 1);
    k = 0;
    prev_fire = 1'b1;
    prev_addr = '0;
    launch(b, len, stride, cnt, dir, 1'b0, 1'b0, ie);
    chk(addr_valid && addr == b, "R2 first address", addr, b);
    while (k < total) begin
      bit r;
      r = ($urandom % 100) >= stall;
      addr_ready = r;
      if (!addr_valid) chk(1'b0, "R5 valid dropped early", k, total);
      if (!prev_fire) chk(addr == prev_addr, "R4 address held under stall", addr, prev_addr);
      chk(addr_dir == dir, "R9 direction", addr_dir, dir);
      if (r) begin
        chk(addr == rect_exp(b, len, stride, k), "R3 rect address", addr,
            rect_exp(b, len, stride, k));
        chk(flags[0] == 1'b0, "R5 done early", flags, 0);
        k++;
      end
      prev_fire = r;
      prev_addr = addr;
      @(negedge clk);
    end
    addr_ready = 1'b0;
    chk(addr_valid == 1'b0, "R5 idle after walk", addr_valid, 0);
    chk(flags[0] == 1'b1, "R5 done set", flags, 1);
    chk(irq == ie, "R10 irq masking", irq, ie);
  endtask

  // Circular mode against a model with random stalls and random clears.
  task automatic run_ring(input logic [29:0] b, input int stride, input int cnt,
                          input bit ie, input int cycles);
    int size, half, idx;
    logic [2:0] mf;
    size = stride * (cnt + 1);
    half = size / 2;
    idx = 0;
    mf = '0;
    launch(b, 0, stride, cnt, 1'b1, 1'b1, 1'b1, ie);
    for (int j = 0; j < cycles; j++) begin
      bit r;
      logic [2:0] c, s;
      chk(addr_valid, "R7 ring stays active", addr_valid, 1);
      chk(addr == b + 30'(idx), "R7 ring address", addr, b + 30'(idx));
      chk(flags == mf, "R8 half flags", flags, mf);
      chk(irq == (ie && mf != 0), "R10 irq", irq, ie && mf != 0);
      r = ($urandom % 4) != 0;
      c = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      addr_ready = r;
      irq_clr = c;
      s = '0;
      if (r) begin
        if (idx == half - 1) s[1] = 1'b1;
        if (idx == size - 1) s[2] = 1'b1;
        idx = (idx == size - 1) ? 0 : idx + 1;
      end
      mf = (mf & ~c) | s;
      @(negedge clk);
    end
    irq_clr = '0;
    addr_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2d01));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(addr_valid == 1'b0, "R1 valid after reset", addr_valid, 0);
    chk(flags == 3'b000, "R1 flags after reset", flags, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);

    // Directed: single word, single line
    run_rect(30'h100, 1, 1, 0, 1'b1, 1'b1, 0);
    // R11 clear of done flag
    irq_clr = 3'b001;
    @(negedge clk);
    irq_clr = 3'b000;
    chk(flags[0] == 1'b0, "R11 done cleared", flags, 0);
    // Gap between lines, address wrap at top, heavy stall
    run_rect(30'h3FFF_FFF0, 3, 7, 3, 1'b0, 1'b0, 60);
    // R10: flag latches although interrupt is disabled
    chk(flags[0] == 1'b1 && irq == 1'b0, "R10 flag without irq", {flags, irq}, 4'b0010);

    // Random rectangular configurations (R2 R3 R4 R5 R9)
    for (int t = 0; t < 24; t++) begin
      int len, cnt, stride;
      len = 1 + ($urandom % 6);
      cnt = $urandom % 5;
      stride = len + ($urandom % 4);
      run_rect(30'($urandom), len, stride, cnt, 1'($urandom), 1'($urandom), 30);
    end

    // R6: circular mode without both enables stays idle
    launch(30'h40, 0, 1, 7, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(addr_valid == 1'b0, "R6 missing half-B enable", addr_valid, 0);
    launch(30'h40, 0, 1, 7, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(addr_valid == 1'b0, "R6 missing loop enable", addr_valid, 0);

    // R7 R8 circular mode
    run_ring(30'h200, 1, 7, 1'b1, 60);
    run_ring(30'h3FFF_FFFC, 2, 3, 1'b0, 50);
    run_ring(30'h1234, 1, 1, 1'b1, 20);

    // R12: stop in a cycle with an accepted last word raises no flag
    launch(30'h80, 1, 1, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    addr_ready = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    addr_ready = 1'b0;
    chk(addr_valid == 1'b0, "R12 idle after stop", addr_valid, 0);
    chk(flags == 3'b000, "R12 no flag on stop", flags, 0);
    // R12: stop during a ring
    run_ring(30'h300, 1, 3, 1'b1, 5);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(addr_valid == 1'b0, "R12 ring stopped", addr_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule